// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block drives a three-wire serial EEPROM of 64 sixteen-bit words on behalf of a host. The host hands over one request at a time, either a read or a write of a single word, and the controller produces every chip-select, clock and data-in transition the memory needs. It samples the memory's data-out line and returns the read word or the result of a write. Every level on the serial clock is held for a programmable number of system clock cycles. The default is sized for a 50 microsecond hold at a 50 MHz system clock.

The host side is a valid/ready request channel. A request moves only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a host that keeps `req_valid` high simply waits. Requests offered while the controller is busy are not taken and have no effect. There is no back-pressure on the response: `rsp_done` pulses for one cycle and the read word and the timeout flag are then held until the next request is accepted.

A read is one command frame followed by sixteen input clocks and a standby toggle of chip select. A write opens with a write-enable command, then sends the write command with its data and polls data-out for the memory's ready level with a bounded number of polls. It then closes with a write-disable command and a cleanup clock with chip select low.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While and right after synchronous reset, `ee_cs`, `ee_sk` and `ee_di` are low, `req_ready` is high and `rsp_done` and `rsp_timeout` are low.
- R2: Every level of `ee_sk` lasts at least PHASE_CYC system clock cycles, and `ee_di` changes only while `ee_sk` is low and was low in the previous cycle.
- R3: A read is a 9-bit command frame sent most significant bit first: start and opcode `110`, then the 6-bit word address. The bits are sampled by the memory on rising `ee_sk`. Sixteen further clocks follow, and `ee_do` is sampled at the end of each high level. The first sampled bit is bit 15 of the word, and the word appears on `rsp_rdata` when `rsp_done` pulses.
- R4: `ee_di` stays low during the sixteen read clocks. A read ends with the standby toggle (chip select low, clock high, chip select high, clock low), so after its `rsp_done` `ee_cs` is high and `ee_sk` is low.
- R5: A write sends the 9-bit write-enable frame `10011` plus four zero bits, then a standby toggle. It then sends a 25-bit frame, MSB first: opcode `101`, the 6-bit address and the 16-bit data word, so a write-enabled memory stores the word.
- R6: After the poll, a write runs a standby toggle and sends the write-disable frame `10000` plus four zero bits. It then drops `ee_cs` and `ee_di` and gives one full clock pulse, so after its `rsp_done` all three device outputs are low and the memory is no longer write-enabled.
- R7: After the data frame and a standby toggle, `ee_do` is polled once per PHASE_CYC cycles for at most POLL_MAX polls. If a poll sees it high, `rsp_timeout` stays low. If no poll sees it high, `rsp_timeout` is set and the disable and cleanup steps still run.
- R8: A request is accepted only when `req_valid` and `req_ready` are high together, `req_ready` is low in the cycle after acceptance until the request completes, and requests offered while busy change nothing.
- R9: `rsp_done` is a one-cycle pulse issued in the first cycle `req_ready` is high again. `rsp_timeout` holds its value until the next acceptance, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Word returned by the last read |
| rsp_timeout | output | 1 | Last write never saw the ready level |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready level from the memory |

## Verification
The bench runs a small configuration against a bit-level memory model that decodes frames from the pins. It writes every one of the 64 addresses with an arithmetic pattern and reads them all back, so address or bit-order faults show up as mismatched words. Writes are stored by the model only if the enable frame arrived. All-zero, all-one and alternating words at the lowest and highest addresses separate stuck data bits from shifted ones. A memory that never becomes ready shows the timeout path and that disable and cleanup still follow it. A write offered during a busy read shows that requests are ignored while `req_ready` is low.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  // Primitive steps the sequencer hands to the pin engine.
  typedef enum logic [2:0] {
    OP_SETUP,
    OP_SHIFT_OUT,
    OP_SHIFT_IN,
    OP_STANDBY,
    OP_POLL,
    OP_CLEANUP
  } mw_op_e;

  // Pin engine phases; every phase holds its pin levels for one delay.
  typedef enum logic [3:0] {
    ES_IDLE,
    ES_SETUP_LOW,
    ES_SETUP_CS,
    ES_BIT_SET,
    ES_BIT_HIGH,
    ES_BIT_LOW,
    ES_IN_HIGH,
    ES_IN_LOW,
    ES_SB_DESEL,
    ES_SB_CLKHI,
    ES_SB_SEL,
    ES_SB_CLKLO,
    ES_POLL,
    ES_CL_DROP,
    ES_CL_HIGH,
    ES_CL_LOW
  } mw_eng_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT
  } mw_seq_state_e;

  // Opcodes carry their leading start bit.
  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [4:0] OPC_WREN  = 5'b10011;
  localparam logic [4:0] OPC_WRDIS = 5'b10000;

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int PHASE_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(PHASE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(PHASE_CYC - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/mw_pin_engine.sv
module mw_pin_engine
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int PHASE_CYC = 2500,
  parameter int POLL_MAX  = 200,
  localparam int FRAME_W  = 3 + ADDR_W + DATA_W,
  localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  mw_op_e             op,
  input  logic [LEN_W-1:0]   len,
  input  logic [FRAME_W-1:0] frame,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic               fin,
  output logic [DATA_W-1:0]  rdata,
  output logic               poll_ok
);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam int ICNT_W = $clog2(DATA_W + 1);

  mw_eng_state_e      state;
  logic [FRAME_W-1:0] sreg;
  logic [LEN_W-1:0]   left;
  logic [ICNT_W-1:0]  in_cnt;
  logic [POLL_W-1:0]  pcnt;
  logic               expired;
  logic               adv;

  // A new phase starts on a go from idle or when the current delay runs out.
  assign adv = (state == ES_IDLE) ? go : expired;

  mw_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (adv),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ES_IDLE;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      fin     <= 1'b0;
      sreg    <= '0;
      left    <= '0;
      in_cnt  <= '0;
      pcnt    <= '0;
      rdata   <= '0;
      poll_ok <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (adv) begin
        unique case (state)
          ES_IDLE: begin
            unique case (op)
              OP_SETUP: begin
                ee_sk <= 1'b0;
                ee_di <= 1'b0;
                state <= ES_SETUP_LOW;
              end
              OP_SHIFT_OUT: begin
                sreg  <= frame;
                left  <= len;
                ee_di <= frame[FRAME_W-1];
                state <= ES_BIT_SET;
              end
              OP_SHIFT_IN: begin
                in_cnt <= '0;
                ee_di  <= 1'b0;
                ee_sk  <= 1'b1;
                state  <= ES_IN_HIGH;
              end
              OP_STANDBY: begin
                ee_cs <= 1'b0;
                ee_sk <= 1'b0;
                state <= ES_SB_DESEL;
              end
              OP_POLL: begin
                pcnt  <= '0;
                state <= ES_POLL;
              end
              default: begin
                ee_cs <= 1'b0;
                ee_di <= 1'b0;
                state <= ES_CL_DROP;
              end
            endcase
          end
          ES_SETUP_LOW: begin
            ee_cs <= 1'b1;
            state <= ES_SETUP_CS;
          end
          ES_SETUP_CS: begin
            state <= ES_IDLE;
            fin   <= 1'b1;
          end
          ES_BIT_SET: begin
            ee_sk <= 1'b1;
            state <= ES_BIT_HIGH;
          end
          ES_BIT_HIGH: begin
            ee_sk <= 1'b0;
            state <= ES_BIT_LOW;
          end
          ES_BIT_LOW: begin
            if (left == LEN_W'(1)) begin
              ee_di <= 1'b0;
              state <= ES_IDLE;
              fin   <= 1'b1;
            end else begin
              sreg  <= sreg << 1;
              left  <= left - 1'b1;
              ee_di <= sreg[FRAME_W-2];
              state <= ES_BIT_SET;
            end
          end
          ES_IN_HIGH: begin
            rdata <= {rdata[DATA_W-2:0], ee_do};
            ee_sk <= 1'b0;
            state <= ES_IN_LOW;
          end
          ES_IN_LOW: begin
            if (in_cnt == ICNT_W'(DATA_W - 1)) begin
              state <= ES_IDLE;
              fin   <= 1'b1;
            end else begin
              in_cnt <= in_cnt + 1'b1;
              ee_sk  <= 1'b1;
              state  <= ES_IN_HIGH;
            end
          end
          ES_SB_DESEL: begin
            ee_sk <= 1'b1;
            state <= ES_SB_CLKHI;
          end
          ES_SB_CLKHI: begin
            ee_cs <= 1'b1;
            state <= ES_SB_SEL;
          end
          ES_SB_SEL: begin
            ee_sk <= 1'b0;
            state <= ES_SB_CLKLO;
          end
          ES_SB_CLKLO: begin
            state <= ES_IDLE;
            fin   <= 1'b1;
          end
          ES_POLL: begin
            if (ee_do) begin
              poll_ok <= 1'b1;
              state   <= ES_IDLE;
              fin     <= 1'b1;
            end else if (pcnt == POLL_W'(POLL_MAX - 1)) begin
              poll_ok <= 1'b0;
              state   <= ES_IDLE;
              fin     <= 1'b1;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          ES_CL_DROP: begin
            ee_sk <= 1'b1;
            state <= ES_CL_HIGH;
          end
          ES_CL_HIGH: begin
            ee_sk <= 1'b0;
            state <= ES_CL_LOW;
          end
          default: begin
            state <= ES_IDLE;
            fin   <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_cmd_seq.sv
module mw_cmd_seq
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  localparam int FRAME_W = 3 + ADDR_W + DATA_W,
  localparam int HDR_W   = 3 + ADDR_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               eng_go,
  output mw_op_e             eng_op,
  output logic [LEN_W-1:0]   eng_len,
  output logic [FRAME_W-1:0] eng_frame,
  input  logic               eng_fin,
  input  logic [DATA_W-1:0]  eng_rdata,
  input  logic               eng_poll_ok,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_timeout
);
  localparam int STEP_W = 4;

  mw_seq_state_e      state;
  logic [STEP_W-1:0]  step;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               last_step;

  // Step table: the read and the write each walk an ordered list of primitives.
  always_comb begin
    eng_op    = OP_SETUP;
    eng_len   = LEN_W'(HDR_W);
    eng_frame = '0;
    last_step = 1'b0;
    if (!wr_q) begin
      unique case (step)
        4'd0: eng_op = OP_SETUP;
        4'd1: begin
          eng_op    = OP_SHIFT_OUT;
          eng_frame = {OPC_READ, addr_q, {DATA_W{1'b0}}};
        end
        4'd2: eng_op = OP_SHIFT_IN;
        default: begin
          eng_op    = OP_STANDBY;
          last_step = 1'b1;
        end
      endcase
    end else begin
      unique case (step)
        4'd0: eng_op = OP_SETUP;
        4'd1: begin
          eng_op    = OP_SHIFT_OUT;
          eng_frame = {OPC_WREN, {(FRAME_W-5){1'b0}}};
        end
        4'd2, 4'd4, 4'd6: eng_op = OP_STANDBY;
        4'd3: begin
          eng_op    = OP_SHIFT_OUT;
          eng_len   = LEN_W'(FRAME_W);
          eng_frame = {OPC_WRITE, addr_q, data_q};
        end
        4'd5: eng_op = OP_POLL;
        4'd7: begin
          eng_op    = OP_SHIFT_OUT;
          eng_frame = {OPC_WRDIS, {(FRAME_W-5){1'b0}}};
        end
        default: begin
          eng_op    = OP_CLEANUP;
          last_step = 1'b1;
        end
      endcase
    end
  end

  assign req_ready = (state == SQ_IDLE);
  assign eng_go    = (state == SQ_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      step        <= '0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            wr_q        <= req_write;
            addr_q      <= req_addr;
            data_q      <= req_wdata;
            step        <= '0;
            rsp_timeout <= 1'b0;
            state       <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: state <= SQ_WAIT;
        default: begin
          if (eng_fin) begin
            if (eng_op == OP_POLL && !eng_poll_ok) begin
              rsp_timeout <= 1'b1;
            end
            if (last_step) begin
              if (!wr_q) begin
                rsp_rdata <= eng_rdata;
              end
              rsp_done <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              step  <= step + 1'b1;
              state <= SQ_ISSUE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int PHASE_CYC = 2500,
  parameter int POLL_MAX  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               eng_go;
  mw_op_e             eng_op;
  logic [LEN_W-1:0]   eng_len;
  logic [FRAME_W-1:0] eng_frame;
  logic               eng_fin;
  logic [DATA_W-1:0]  eng_rdata;
  logic               eng_poll_ok;

  mw_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .eng_go      (eng_go),
    .eng_op      (eng_op),
    .eng_len     (eng_len),
    .eng_frame   (eng_frame),
    .eng_fin     (eng_fin),
    .eng_rdata   (eng_rdata),
    .eng_poll_ok (eng_poll_ok),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .rsp_timeout (rsp_timeout)
  );

  mw_pin_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_CYC(PHASE_CYC), .POLL_MAX(POLL_MAX)
  ) eng_i (
    .clk     (clk),
    .rst     (rst),
    .go      (eng_go),
    .op      (eng_op),
    .len     (eng_len),
    .frame   (eng_frame),
    .ee_do   (ee_do),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di),
    .fin     (eng_fin),
    .rdata   (eng_rdata),
    .poll_ok (eng_poll_ok)
  );

endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
  parameter int PHASE_CYC = 2500
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic rsp_timeout,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  localparam int CW = $clog2(PHASE_CYC + 1);

  logic [CW-1:0] run;
  logic          sk_prev;

  // Length of the current clock level, saturating at one delay.
  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      sk_prev <= 1'b0;
    end else begin
      sk_prev <= ee_sk;
      if (ee_sk != sk_prev) begin
        run <= CW'(1);
      end else if (run < CW'(PHASE_CYC)) begin
        run <= run + 1'b1;
      end
    end
  end

  p_reset_pins_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ee_cs && !ee_sk && !ee_di && req_ready && !rsp_done && !rsp_timeout));

  p_sk_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ee_sk != sk_prev) |-> (run >= CW'(PHASE_CYC)));

  p_di_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ee_di) |-> (!ee_sk && !$past(ee_sk)));

  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !rsp_timeout));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_done_ready_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);

endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.PHASE_CYC(PHASE_CYC)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .ee_cs       (ee_cs),
  .ee_sk       (ee_sk),
  .ee_di       (ee_di)
);

// File: tb/mw_eeprom_ctrl_tb_top.sv
module mw_eeprom_ctrl_tb_top;
  localparam int PHASE    = 3;
  localparam int POLLS    = 8;
  localparam int BUSY_LEN = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        rsp_timeout;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mw_eeprom_ctrl #(.PHASE_CYC(PHASE), .POLL_MAX(POLLS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // ---------------- bit-level memory model ----------------
  logic [15:0] mem [64];
  logic        cs_d, sk_d;
  int          bcnt, mode, ridx, busy, commits, rd_di_bad;
  logic [24:0] sh;
  logic [5:0]  maddr;
  bit          pend, en, stuck;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
      cs_d = 0; sk_d = 0; bcnt = 0; mode = 0; ridx = 0; busy = 0;
      commits = 0; rd_di_bad = 0; sh = '0; maddr = '0; pend = 0; en = 0;
      ee_do <= 1'b1;
    end else begin
      if (ee_cs && !cs_d) begin bcnt = 0; sh = '0; mode = 0; end
      if (!ee_cs && cs_d && pend) begin busy = BUSY_LEN; pend = 0; end
      else if (busy > 0) busy--;
      if (ee_cs && ee_sk && !sk_d) begin
        if (mode == 1) begin
          if (ee_di) rd_di_bad++;
          if (ridx < 16) begin ee_do <= mem[maddr][15-ridx]; ridx++; end
        end else begin
          sh = {sh[23:0], ee_di};
          bcnt++;
          if (bcnt == 9) begin
            case (sh[8:6])
              3'b110: begin mode = 1; maddr = sh[5:0]; ridx = 0; end
              3'b101: begin mode = 2; maddr = sh[5:0]; end
              3'b100: begin
                if (sh[5:4] == 2'b11) en = 1;
                else if (sh[5:4] == 2'b00) en = 0;
              end
              default: ;
            endcase
          end
          if (bcnt == 25 && mode == 2) begin
            if (en) begin mem[maddr] = sh[15:0]; commits++; end
            pend = 1; mode = 3;
          end
        end
      end
      if (mode != 1) ee_do <= (busy == 0) && !stuck;
      cs_d = ee_cs; sk_d = ee_sk;
    end
  end

  // ---------------- pin timing monitor ----------------
  int   run_len = 0, min_level = 1000, di_bad = 0;
  logic sk_n = 0, di_n = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ee_di != di_n && (ee_sk || sk_n)) di_bad++;
      if (ee_sk != sk_n) begin
        if (run_len < min_level) min_level = run_len;
        run_len = 1;
      end else run_len++;
    end
    sk_n = ee_sk; di_n = ee_di;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503 + 4660) ^ (a << 10));
  endfunction

  task automatic run_req(input bit wr, input logic [5:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output logic to);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 ready low after accept", 32'(req_ready), 0);
    chk(!rsp_timeout, "R9 timeout cleared on accept", 32'(rsp_timeout), 0);
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata; to = rsp_timeout;
    @(negedge clk);
    chk(!rsp_done, "R9 done lasts one cycle", 32'(rsp_done), 0);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input bit exp_to);
    logic [15:0] rd; logic to;
    run_req(1, a, d, rd, to);
    chk(to == exp_to, "R7 timeout flag", 32'(to), 32'(exp_to));
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R6 pins low after cleanup", 32'({ee_cs, ee_sk, ee_di}), 0);
    chk(!en, "R6 write disabled after write", 32'(en), 0);
    if (!exp_to) chk(mem[a] == d, "R5 word stored", 32'(mem[a]), 32'(d));
  endtask

  task automatic do_read(input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] rd; logic to;
    run_req(0, a, 16'h0, rd, to);
    chk(rd == exp, "R3 read word", 32'(rd), 32'(exp));
    chk(ee_cs && !ee_sk, "R4 standby leaves cs high sk low", 32'({ee_cs, ee_sk}), 32'(2));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rd; logic to; int c0;
    stuck = 0;
    repeat (4) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins low in reset", 32'({ee_cs, ee_sk, ee_di}), 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_timeout, "R1 idle flags after reset",
        32'({req_ready, rsp_done, rsp_timeout}), 32'(4));
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins low after reset", 32'({ee_cs, ee_sk, ee_di}), 0);

    // full address sweep
    for (int a = 0; a < 64; a++) do_write(6'(a), pat(a), 0);
    for (int a = 0; a < 64; a++) do_read(6'(a), pat(a));

    // data patterns at the end addresses
    do_write(6'd0, 16'h0000, 0);  do_read(6'd0, 16'h0000);
    do_write(6'd63, 16'hFFFF, 0); do_read(6'd63, 16'hFFFF);
    do_write(6'd0, 16'hAAAA, 0);  do_read(6'd0, 16'hAAAA);
    do_write(6'd63, 16'h5555, 0); do_read(6'd63, 16'h5555);
    do_read(6'd1, pat(1));

    // ready never seen: timeout, disable and cleanup still happen
    stuck = 1;
    do_write(6'd9, 16'h1357, 1);
    @(negedge clk);
    chk(rsp_timeout, "R7 timeout held until next request", 32'(rsp_timeout), 1);
    stuck = 0;
    do_read(6'd2, pat(2));
    chk(!rsp_timeout, "R9 timeout cleared by next request", 32'(rsp_timeout), 0);

    // a write offered while busy is ignored
    c0 = commits;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 6'd5;
    @(negedge clk);
    req_write = 1; req_addr = 6'd7; req_wdata = 16'hDEAD;
    repeat (20) @(negedge clk);
    req_valid = 0;
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    chk(rd == pat(5), "R3 read during busy offer", 32'(rd), 32'(pat(5)));
    repeat (40 * PHASE) @(negedge clk);
    chk(commits == c0, "R8 busy request not performed", 32'(commits), 32'(c0));
    chk(mem[7] == pat(7), "R8 busy request left word", 32'(mem[7]), 32'(pat(7)));
    do_read(6'd7, pat(7));

    chk(rd_di_bad == 0, "R4 di low while reading", 32'(rd_di_bad), 0);
    chk(min_level >= PHASE, "R2 sk level length", 32'(min_level), 32'(PHASE));
    chk(di_bad == 0, "R2 di moves only with sk low", 32'(di_bad), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule